// File: doc/BRIEF.md
# Low-Speed Oscillator Enable Controller

This block holds the control and status fields for an external low-speed crystal oscillator. Software writes an enable field and a bypass field over a single-cycle register write port and reads all fields back on a combinational read port. The oscillator itself sits outside the block and appears only as a slow clock input. The enable and bypass values go out to the oscillator and also cross into the slow clock domain.

In the slow domain a stabilisation counter decides when the oscillator is ready. After the oscillator has been switched on, the ready flag rises once a programmable number of slow-clock edges has passed. A separate, shorter count applies when the bypass field is set. After the oscillator is switched off, the ready flag falls a fixed number of slow-clock edges later. The ready flag returns to the bus clock through a two-flop synchroniser before software can read it. The bypass field can only be changed while the oscillator is off.

Top module: `lsosc_ctrl`

## Requirements
- R1: After reset, the read port returns 0 in every bit, and `osc_en_o` and `osc_byp_o` are 0.
- R2: A write stores `reg_wdata[0]` as the enable field, where 1 means on. From the next `clk` cycle, the new value shows in `reg_rdata[0]` and on `osc_en_o`.
- R3: Bit 1 of the read port is the ready flag, and software cannot write it. Writing 1 to bit 1 while the oscillator is off leaves `reg_rdata[1]` at 0.
- R4: With bypass at 0, the ready flag rises on slow-clock edge ON_CYCLES (default 2048). Edge 1 is the first `osc_clk` rising edge after the `clk` edge that stored enable = 1. Before that edge the flag stays 0.
- R5: With bypass at 1, the ready flag rises on slow-clock edge BYP_CYCLES (default 16), counted from the enable write in the same way as in R4.
- R6: After the enable field is cleared, the ready flag stays 1 through slow edge OFF_CYCLES-1 and reads 0 after edge OFF_CYCLES (default 6). Edges are counted from the clearing write in the same way as in R4.
- R7: A write stores `reg_wdata[2]` as the bypass field, where 1 means bypassed. The new value shows in `reg_rdata[2]` and on `osc_byp_o`. The write takes effect only if the stored enable field is 0 at the time of the write; otherwise the old bypass value is kept.
- R8: If the enable field is set again while the off countdown is still running, the ready flag never falls. The countdown is cancelled.
- R9: Read-port bits from 3 up to DATA_W-1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| osc_clk | input | 1 | Low-speed oscillator clock |
| reg_wr | input | 1 | Register write strobe, one `clk` cycle per write |
| reg_wdata | input | DATA_W | Write data: bit 0 is enable, bit 2 is bypass |
| reg_rdata | output | DATA_W | Read data: bit 0 is enable, bit 1 is ready, bit 2 is bypass |
| osc_en_o | output | 1 | Enable to the oscillator |
| osc_byp_o | output | 1 | Bypass select to the oscillator |

## Verification
The embedded properties check the following on every cycle:
- A write loads the enable field.
- The bypass field holds while the oscillator is enabled.
- The slow-domain ready flag rises only while the synchronised enable is high and falls only while it is low.
- The stabilisation counter never passes its largest limit.

Only the directed scenarios show the exact number of slow edges for both rise lengths and for the six-edge fall, the cancelled countdown, the read-only ready bit and the reset values. The bench measures these at the read port, counting slow-clock edges.

// File: rtl/lsosc_pkg.sv
package lsosc_pkg;

   // Field positions decoded by software drivers
   localparam int unsigned FLD_EN  = 0;
   localparam int unsigned FLD_RDY = 1;
   localparam int unsigned FLD_BYP = 2;
   localparam int unsigned FLD_CNT = 3;

   // Smallest count the stabilisation counter can honour
   // (two synchroniser edges plus one counting edge)
   localparam int unsigned MIN_COUNT = 3;

   typedef struct packed {
      logic byp;
      logic en;
   } ctl_t;

endpackage

// File: rtl/lsosc_sync.sv
module lsosc_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("lsosc_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lsosc_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/lsosc_regs.sv
module lsosc_regs
   import lsosc_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              rdy_bus,
   output ctl_t              ctl,
   output logic [DATA_W-1:0] rdata
);

   if (DATA_W < FLD_CNT) begin : g_bad_width
      $error("lsosc_regs: DATA_W too small for the field map");
   end

   logic en_q;
   logic byp_q;
   logic byp_ok;

   // Bypass may only move while the oscillator is off
   assign byp_ok = wr && !en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         byp_q <= 1'b0;
      end else begin
         if (wr)     en_q  <= wdata[FLD_EN];
         if (byp_ok) byp_q <= wdata[FLD_BYP];
      end
   end

   assign ctl.en  = en_q;
   assign ctl.byp = byp_q;

   always_comb begin
      rdata          = '0;
      rdata[FLD_EN]  = en_q;
      rdata[FLD_RDY] = rdy_bus;
      rdata[FLD_BYP] = byp_q;
   end

   p_en_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (en_q == $past(wdata[FLD_EN])));

   p_byp_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && en_q) |=> $stable(byp_q));

   p_no_write_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> ($stable(byp_q) && $stable(en_q)));

endmodule

// File: rtl/lsosc_stab.sv
module lsosc_stab
   import lsosc_pkg::*;
#(
   parameter int unsigned ON_CYCLES  = 2048,
   parameter int unsigned BYP_CYCLES = 16,
   parameter int unsigned OFF_CYCLES = 6
) (
   input  logic osc_clk,
   input  logic osc_rst_n,
   input  ctl_t ctl_s,
   output logic rdy
);

   localparam int unsigned MAX_A   = (ON_CYCLES > BYP_CYCLES) ? ON_CYCLES : BYP_CYCLES;
   localparam int unsigned MAX_LIM = (MAX_A > OFF_CYCLES) ? MAX_A : OFF_CYCLES;
   localparam int unsigned CNT_W   = $clog2(MAX_LIM + 1);
   localparam logic [CNT_W-1:0] TERM_ON  = CNT_W'(ON_CYCLES  - MIN_COUNT);
   localparam logic [CNT_W-1:0] TERM_BYP = CNT_W'(BYP_CYCLES - MIN_COUNT);
   localparam logic [CNT_W-1:0] TERM_OFF = CNT_W'(OFF_CYCLES - MIN_COUNT);
   localparam logic [CNT_W-1:0] TERM_MAX = CNT_W'(MAX_LIM    - MIN_COUNT);

   if (ON_CYCLES < MIN_COUNT) begin : g_bad_on
      $error("lsosc_stab: ON_CYCLES below minimum");
   end
   if (BYP_CYCLES < MIN_COUNT) begin : g_bad_byp
      $error("lsosc_stab: BYP_CYCLES below minimum");
   end
   if (OFF_CYCLES < MIN_COUNT) begin : g_bad_off
      $error("lsosc_stab: OFF_CYCLES below minimum");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] term;
   logic             target;

   // The flag chases the synchronised enable with a per-direction length
   assign target = ctl_s.en;

   always_comb begin
      if (!target)       term = TERM_OFF;
      else if (ctl_s.byp) term = TERM_BYP;
      else               term = TERM_ON;
   end

   always_ff @(posedge osc_clk or negedge osc_rst_n) begin
      if (!osc_rst_n) begin
         cnt <= '0;
         rdy <= 1'b0;
      end else if (target == rdy) begin
         cnt <= '0;
      end else if (cnt >= term) begin
         cnt <= '0;
         rdy <= target;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   p_rise_needs_en_r4: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      $rose(rdy) |-> $past(ctl_s.en));

   p_fall_needs_off_r6: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      $fell(rdy) |-> !$past(ctl_s.en));

   p_cnt_bound_r5: assert property (@(posedge osc_clk) disable iff (!osc_rst_n)
      cnt <= TERM_MAX);

endmodule

// File: rtl/lsosc_ctrl.sv
module lsosc_ctrl
   import lsosc_pkg::*;
#(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ON_CYCLES  = 2048,
   parameter int unsigned BYP_CYCLES = 16,
   parameter int unsigned OFF_CYCLES = 6,
   parameter int unsigned SYNC_STG   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              osc_clk,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              osc_en_o,
   output logic              osc_byp_o
);

   localparam int unsigned CTL_W = $bits(ctl_t);

   ctl_t ctl_bus;
   ctl_t ctl_slow;
   logic osc_rst_n;
   logic rdy_slow;
   logic rdy_bus;

   // Reset release aligned to the slow clock
   lsosc_sync #(.WIDTH(1), .STAGES(SYNC_STG)) u_rst_sync (
      .clk   (osc_clk),
      .rst_n (rst_n),
      .d     (1'b1),
      .q     (osc_rst_n)
   );

   lsosc_regs #(.DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .wdata   (reg_wdata),
      .rdy_bus (rdy_bus),
      .ctl     (ctl_bus),
      .rdata   (reg_rdata)
   );

   lsosc_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STG)) u_ctl_sync (
      .clk   (osc_clk),
      .rst_n (osc_rst_n),
      .d     (ctl_bus),
      .q     (ctl_slow)
   );

   lsosc_stab #(
      .ON_CYCLES  (ON_CYCLES),
      .BYP_CYCLES (BYP_CYCLES),
      .OFF_CYCLES (OFF_CYCLES)
   ) u_stab (
      .osc_clk   (osc_clk),
      .osc_rst_n (osc_rst_n),
      .ctl_s     (ctl_slow),
      .rdy       (rdy_slow)
   );

   lsosc_sync #(.WIDTH(1), .STAGES(SYNC_STG)) u_rdy_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rdy_slow),
      .q     (rdy_bus)
   );

   assign osc_en_o  = ctl_bus.en;
   assign osc_byp_o = ctl_bus.byp;

endmodule

// File: tb/sim_lsosc_ctrl.sv
module sim_lsosc_ctrl;

   localparam int DW  = 32;
   localparam int ONC = 2048;
   localparam int BYC = 16;
   localparam int OFC = 6;

   logic          clk = 1'b0;
   logic          osc_clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          osc_en_o;
   logic          osc_byp_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;
   initial begin
      #13;
      forever #40 osc_clk = ~osc_clk;
   end

   lsosc_ctrl #(.DATA_W(DW), .ON_CYCLES(ONC), .BYP_CYCLES(BYC), .OFF_CYCLES(OFC)) u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .osc_clk   (osc_clk),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .osc_en_o  (osc_en_o),
      .osc_byp_o (osc_byp_o)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(logic [DW-1:0] v);
      @(negedge clk);
      reg_wr    = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_wdata = '0;
   endtask

   // wait n slow rising edges, then sample at the following falling edge
   task automatic slow_edges(int n);
      repeat (n) @(posedge osc_clk);
      @(negedge osc_clk);
   endtask

   task automatic t_reset_r1();
      check("R1 rdata", reg_rdata, '0);
      check("R1 osc_en_o", {31'b0, osc_en_o}, 32'd0);
      check("R1 osc_byp_o", {31'b0, osc_byp_o}, 32'd0);
   endtask

   task automatic t_ready_ro_r3();
      bus_write(32'h2);
      slow_edges(4);
      check("R3 ready not writable", {31'b0, reg_rdata[1]}, 32'd0);
      check("R3 enable untouched", {31'b0, reg_rdata[0]}, 32'd0);
   endtask

   task automatic t_byp_idle_r7();
      bus_write(32'h4);
      check("R7 bypass set while off", {31'b0, reg_rdata[2]}, 32'd1);
      check("R7 osc_byp_o set", {31'b0, osc_byp_o}, 32'd1);
      bus_write(32'h0);
      check("R7 bypass cleared while off", {31'b0, reg_rdata[2]}, 32'd0);
      slow_edges(3);
   endtask

   task automatic t_on_r4();
      bus_write(32'h1);
      check("R2 enable read back", {31'b0, reg_rdata[0]}, 32'd1);
      check("R2 osc_en_o", {31'b0, osc_en_o}, 32'd1);
      slow_edges(1);
      check("R4 ready low at edge 1", {31'b0, reg_rdata[1]}, 32'd0);
      slow_edges(ONC - 2);
      check("R4 ready low at edge ON-1", {31'b0, reg_rdata[1]}, 32'd0);
      slow_edges(1);
      check("R4 ready high at edge ON", {31'b0, reg_rdata[1]}, 32'd1);
   endtask

   task automatic t_byp_guard_r7();
      bus_write(32'h5);
      check("R7 bypass held while on", {31'b0, reg_rdata[2]}, 32'd0);
      check("R7 enable still on", {31'b0, reg_rdata[0]}, 32'd1);
   endtask

   task automatic t_off_r6();
      bus_write(32'h0);
      check("R2 enable cleared", {31'b0, osc_en_o}, 32'd0);
      for (int k = 1; k < OFC; k++) begin
         slow_edges(1);
         check($sformatf("R6 ready still high at edge %0d", k), {31'b0, reg_rdata[1]}, 32'd1);
      end
      slow_edges(1);
      check("R6 ready low at edge OFF", {31'b0, reg_rdata[1]}, 32'd0);
   endtask

   task automatic t_byp_on_r5();
      bus_write(32'h4);
      slow_edges(3);
      bus_write(32'h5);
      slow_edges(BYC - 1);
      check("R5 ready low at edge BYP-1", {31'b0, reg_rdata[1]}, 32'd0);
      slow_edges(1);
      check("R5 ready high at edge BYP", {31'b0, reg_rdata[1]}, 32'd1);
      check("R5 bypass kept", {31'b0, reg_rdata[2]}, 32'd1);
   endtask

   task automatic t_cancel_r8();
      int drops = 0;
      bus_write(32'h4);
      repeat (2) @(posedge osc_clk);
      bus_write(32'h5);
      for (int k = 0; k < 12; k++) begin
         @(negedge osc_clk);
         if (reg_rdata[1] !== 1'b1) drops++;
      end
      check("R8 ready never fell", drops, 32'd0);
   endtask

   task automatic t_upper_r9();
      bus_write('1);
      check("R9 upper bits zero", {3'b0, reg_rdata[DW-1:3]}, '0);
      check("R9 ready still high", {31'b0, reg_rdata[1]}, 32'd1);
   endtask

   initial begin
      repeat (4) @(posedge clk);
      @(negedge clk);
      t_reset_r1();
      rst_n = 1'b1;
      slow_edges(4);
      t_reset_r1();
      t_ready_ro_r3();
      t_byp_idle_r7();
      t_on_r4();
      t_byp_guard_r7();
      t_off_r6();
      t_byp_on_r5();
      t_cancel_r8();
      t_upper_r9();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule